// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block watches the stream of latched byte writes that a page-load front end hands to the array commit logic of a byte-wide nonvolatile memory. It holds a persistent protection flag. It recognises two command sequences, each a fixed list of address and data pairs: an arming sequence and a disarming sequence. For every write it raises a single-cycle qualifier that says whether that byte may be committed to the array. Command bytes are never committed. While protection is on, a byte is committed only if the arming sequence has already appeared earlier in the same load window.

The page-load logic drives `wr_valid` for one cycle for each byte it latches. It pulses `win_close` when a load window ends, either because the window filled or because the byte-load gap ran out. It pulses `prog_done` when the programming period that follows the window has finished. Any change to the protection flag takes effect only on that last pulse. The timer and read polling run upstream whether or not any byte is committed.

Top module: `wp_cmd_detect`

## Requirements
- R1: Out of reset `prot_active` is 0, and `commit_ok` is 0 whenever `wr_valid` is 0.
- R2: With protection off, a write that matches no step of either command sequence gives `commit_ok` = 1 in the same cycle as `wr_valid`.
- R3: Each write of the arming sequence (default 0xAA at 0x1555, 0x55 at 0x0AAA, 0xA0 at 0x1555, in that order) gives `commit_ok` = 0.
- R4: Completing the arming sequence sets `prot_active` in the cycle after the next `prog_done` pulse, and not earlier. Closing the window alone does not set it.
- R5: With protection on, a write in a window where the arming sequence has not yet completed gives `commit_ok` = 0.
- R6: With protection on, once the arming sequence completes in a window, later writes in that window that are not command steps give `commit_ok` = 1. This includes writes to a command address with other data.
- R7: A `win_close` pulse cancels both a half-entered sequence and an unlock gained in that window. A sequence split across two windows does not unlock.
- R8: A write that does not match the expected step returns the matcher to step one. If that write equals the first step, it counts as step one of a new attempt.
- R9: The disarming sequence (default 0xAA at 0x1555, 0x55 at 0x0AAA, 0x80 at 0x1555, 0xAA at 0x1555, 0x55 at 0x0AAA, 0x20 at 0x1555) has every byte stripped. It clears `prot_active` in the cycle after the next `prog_done`, and later writes then commit.
- R10: Protection stays set across any number of windows and programming periods until the disarming sequence is issued.
- R11: `prot_active` changes only in the cycle after a `prog_done` pulse. A `prog_done` pulse with no pending command leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One latched byte write this cycle |
| wr_addr | input | 13 | Address of the latched write |
| wr_data | input | 8 | Data of the latched write |
| win_close | input | 1 | Load window ended, pulse |
| prog_done | input | 1 | Programming period finished, pulse |
| prot_active | output | 1 | Protection flag |
| commit_ok | output | 1 | This write's byte may be committed |

## Verification
The bench builds the detector with its default parameters: a 13-bit address, 8-bit data, a three-step arming list and a six-step disarming list. The first two steps of the disarming list are the same as the first two of the arming list. With those defaults, one write can advance both matchers, and the two matchers then part ways at step three. This exercises the stripping of bytes that only one matcher still claims. It also exercises restart on a repeated first step, sequences split by a window boundary, and the ordering of flag changes against `prog_done`.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Protection change waiting for the end of programming
  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_SET   = 2'd1,
    PEND_CLEAR = 2'd2
  } pend_e;
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match #(
  parameter int AW  = 13,
  parameter int DW  = 8,
  parameter int LEN = 3,
  parameter logic [LEN*AW-1:0] ADDRS = '0,
  parameter logic [LEN*DW-1:0] DATAS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          is_cmd,
  output logic          seq_done
);
  localparam int SW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(LEN - 1);

  logic [AW-1:0] addr_tab [LEN];
  logic [DW-1:0] data_tab [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_tab
    assign addr_tab[i] = ADDRS[i*AW +: AW];
    assign data_tab[i] = DATAS[i*DW +: DW];
  end

  logic [SW-1:0] step_q, step_d;
  logic          hit_cur, hit_first;

  always_comb begin
    hit_cur   = wr_valid && (wr_addr == addr_tab[step_q]) && (wr_data == data_tab[step_q]);
    hit_first = wr_valid && (wr_addr == addr_tab[0]) && (wr_data == data_tab[0]);
    step_d    = step_q;
    if (clr) begin
      step_d = '0;
    end else if (wr_valid) begin
      if (hit_cur) begin
        step_d = (step_q == LAST) ? '0 : step_q + SW'(1);
      end else if (hit_first) begin
        step_d = SW'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  assign is_cmd   = hit_cur || hit_first;
  assign seq_done = hit_cur && (step_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (wr_valid || clr) begin
      step_q <= step_d;
    end
  end

  // R8
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_q) < LEN);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !is_cmd) |=> (step_q == '0));

  initial begin
    len_param_chk: assert (LEN >= 2);
  end
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_done,
  input  logic dis_done,
  input  logic win_close,
  input  logic prog_done,
  output logic prot_q,
  output logic unlock_q
);
  pend_e pend_q, pend_d;
  logic  prot_d, unlock_d;

  always_comb begin
    unlock_d = unlock_q;
    if (win_close)    unlock_d = 1'b0;
    else if (en_done) unlock_d = 1'b1;

    pend_d = pend_q;
    if (prog_done)     pend_d = PEND_NONE;
    else if (en_done)  pend_d = PEND_SET;
    else if (dis_done) pend_d = PEND_CLEAR;

    prot_d = prot_q;
    if (prog_done) begin
      if (pend_q == PEND_SET)        prot_d = 1'b1;
      else if (pend_q == PEND_CLEAR) prot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q   <= 1'b0;
      unlock_q <= 1'b0;
      pend_q   <= PEND_NONE;
    end else begin
      if (win_close || en_done)              unlock_q <= unlock_d;
      if (prog_done || en_done || dis_done)  pend_q   <= pend_d;
      if (prog_done)                         prot_q   <= prot_d;
    end
  end

  // R11
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(prot_q));

  // R7
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> !unlock_q);

  // R4
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && pend_q == PEND_NONE) |=> (prot_q == $past(prot_q)));
endmodule

// File: rtl/wp_cmd_detect.sv
module wp_cmd_detect #(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int EN_LEN  = 3,
  parameter int DIS_LEN = 6,
  parameter logic [EN_LEN*AW-1:0]  EN_ADDRS  = {13'h1555, 13'h0AAA, 13'h1555},
  parameter logic [EN_LEN*DW-1:0]  EN_DATAS  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [DIS_LEN*AW-1:0] DIS_ADDRS = {13'h1555, 13'h0AAA, 13'h1555,
                                                13'h1555, 13'h0AAA, 13'h1555},
  parameter logic [DIS_LEN*DW-1:0] DIS_DATAS = {8'h20, 8'h55, 8'hAA,
                                                8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_close,
  input  logic          prog_done,
  output logic          prot_active,
  output logic          commit_ok
);
  logic en_cmd, en_done, dis_cmd, dis_done, unlock;

  wp_seq_match #(.AW(AW), .DW(DW), .LEN(EN_LEN), .ADDRS(EN_ADDRS), .DATAS(EN_DATAS)) u_en (
    .clk(clk), .rst_n(rst_n), .clr(win_close), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .is_cmd(en_cmd), .seq_done(en_done));

  wp_seq_match #(.AW(AW), .DW(DW), .LEN(DIS_LEN), .ADDRS(DIS_ADDRS), .DATAS(DIS_DATAS)) u_dis (
    .clk(clk), .rst_n(rst_n), .clr(win_close), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .is_cmd(dis_cmd), .seq_done(dis_done));

  wp_prot_state u_state (
    .clk(clk), .rst_n(rst_n), .en_done(en_done), .dis_done(dis_done),
    .win_close(win_close), .prog_done(prog_done),
    .prot_q(prot_active), .unlock_q(unlock));

  always_comb begin
    commit_ok = wr_valid && !en_cmd && !dis_cmd && (!prot_active || unlock);
  end

  // R1
  commit_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> wr_valid);

  // R3
  cmd_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_done || dis_done) |-> !commit_ok);
endmodule

// File: tb/wp_cmd_detect_tb_top.sv
module wp_cmd_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        win_close = 1'b0;
  logic        prog_done = 1'b0;
  logic        prot_active, commit_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sbq[$];
  item_t mon_it;

  always #2 clk = ~clk;

  wp_cmd_detect dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_close(win_close), .prog_done(prog_done),
    .prot_active(prot_active), .commit_ok(commit_ok));

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit e, input string t);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    sbq.push_back('{e, t});
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic close_win();
    @(posedge clk); #1 win_close = 1'b1;
    @(posedge clk); #1 win_close = 1'b0;
  endtask

  task automatic prog_end();
    @(posedge clk); #1 prog_done = 1'b1;
    @(posedge clk); #1 prog_done = 1'b0;
  endtask

  task automatic chk_prot(input bit e, input string t);
    @(negedge clk);
    checks++;
    if (prot_active !== e) begin
      errors++;
      $display("FAIL %s prot_active=%0b expected %0b", t, prot_active, e);
    end
  endtask

  // Monitor: pops expected commit qualifiers as writes appear
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty commit_ok=%0b expected none", commit_ok);
      end else begin
        mon_it = sbq.pop_front();
        if (commit_ok !== mon_it.exp) begin
          errors++;
          $display("FAIL %s commit_ok=%0b expected %0b", mon_it.tag, commit_ok, mon_it.exp);
        end
      end
    end
  end

  task automatic arm_seq(input string t);
    wr(13'h1555, 8'hAA, 1'b0, t);
    wr(13'h0AAA, 8'h55, 1'b0, t);
    wr(13'h1555, 8'hA0, 1'b0, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (prot_active !== 1'b0 || commit_ok !== 1'b0) begin
      errors++;
      $display("FAIL R1 prot/commit=%0b%0b expected 00", prot_active, commit_ok);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    chk_prot(1'b0, "R1 after release");

    // R2: plain writes commit while unprotected
    wr(13'h0100, 8'h11, 1'b1, "R2 plain");
    wr(13'h1555, 8'h12, 1'b1, "R2 command address other data");
    close_win(); prog_end();
    chk_prot(1'b0, "R2 stays off");

    // R3/R4: arming sequence stripped, takes effect at prog_done
    arm_seq("R3 arm byte");
    wr(13'h0200, 8'h33, 1'b1, "R4 still unprotected");
    chk_prot(1'b0, "R4 before close");
    close_win();
    chk_prot(1'b0, "R4 after close");
    prog_end();
    chk_prot(1'b1, "R4 after prog_done");

    // R5: protected write without prefix
    wr(13'h0300, 8'h55, 1'b0, "R5 no prefix");
    wr(13'h0301, 8'h66, 1'b0, "R5 no prefix");
    close_win(); prog_end();
    chk_prot(1'b1, "R10 persists");

    // R6: prefix then data
    arm_seq("R6 prefix byte");
    wr(13'h1555, 8'h77, 1'b1, "R6 data at command address");
    wr(13'h0AAA, 8'h55, 1'b1, "R6 step-two pair after unlock");
    wr(13'h0400, 8'h88, 1'b1, "R6 data");
    close_win(); prog_end();
    chk_prot(1'b1, "R10 persists after unlocked write");

    // R7: split sequence and unlock cleared by window end
    wr(13'h1555, 8'hAA, 1'b0, "R7 step1");
    wr(13'h0AAA, 8'h55, 1'b0, "R7 step2");
    close_win();
    wr(13'h1555, 8'hA0, 1'b0, "R7 step3 new window");
    wr(13'h0500, 8'h99, 1'b0, "R7 still locked");
    close_win(); prog_end();
    chk_prot(1'b1, "R7 prot kept");

    // R8: restart on repeated first step
    wr(13'h1555, 8'hAA, 1'b0, "R8 first");
    wr(13'h1555, 8'hAA, 1'b0, "R8 restart");
    wr(13'h0AAA, 8'h55, 1'b0, "R8 step2");
    wr(13'h1555, 8'hA0, 1'b0, "R8 step3");
    wr(13'h0600, 8'h12, 1'b1, "R8 unlocked data");
    close_win(); prog_end();

    // R9: disarming sequence
    wr(13'h1555, 8'hAA, 1'b0, "R9 dis1");
    wr(13'h0AAA, 8'h55, 1'b0, "R9 dis2");
    wr(13'h1555, 8'h80, 1'b0, "R9 dis3");
    wr(13'h1555, 8'hAA, 1'b0, "R9 dis4");
    wr(13'h0AAA, 8'h55, 1'b0, "R9 dis5");
    wr(13'h1555, 8'h20, 1'b0, "R9 dis6");
    wr(13'h0700, 8'h01, 1'b0, "R9 still protected");
    chk_prot(1'b1, "R11 before prog_done");
    close_win();
    chk_prot(1'b1, "R11 after close");
    prog_end();
    chk_prot(1'b0, "R9 cleared");
    wr(13'h0700, 8'h02, 1'b1, "R9 commit after disarm");
    close_win();

    // R11: idle prog_done leaves flag alone
    prog_end();
    chk_prot(1'b0, "R11 idle prog_done");

    repeat (2) @(posedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard leftover=%0d expected 0", sbq.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule